// File: doc/BRIEF.md
# Pad-Control Register Bank for External Bus and Port Pull-ups

This block holds the pad-level settings for a small controller's external memory bus and its general-purpose ports. Software reaches it through a simple synchronous register interface that uses byte addresses and 8-bit data. One control register can pull the whole external address bus low, the whole external data bus low, or both. When a force bit is clear, that bus passes the value supplied by the memory controller.

Twelve more registers hold one pull-up enable bit per port pin. Before a pull-up reaches a pad it is gated twice. A pin that does not exist never gets a pull-up. A pin driven as an output never gets one either, and this holds no matter which function owns the pin. Every register write is blocked while the write-protect input is high.

Top module: `pad_ctl_bank`

## Requirements
- R1: After reset the drive control register reads 0x00. Each pull-up register reads its per-port reset value. By default these are 0x40 for port 3, 0x08 for port 5, 0xFF for port 6, 0x80 for port 7, 0x02 for port 10, and 0x00 for every other port.
- R2: The drive control register sits at the base address (default 0x300320). An unprotected write there takes effect at the next clock edge. Bit 1 is the data-bus force and bit 0 is the address-bus force. Bits 7..2 always read 0.
- R3: While the data-bus force bit is 1, `pad_data` is all zeros. While it is 0, `pad_data` equals `mc_data`.
- R4: While the address-bus force bit is 1, `pad_addr` is all zeros. While it is 0, `pad_addr` equals `mc_addr`.
- R5: The pull-up register of port k (k = 0..11) is at base+1+k, and bit i controls pin i of that port. Bits of pins that do not exist read 0 and ignore writes. By default port 2 has only pins 0..5 (mask 0x3F), port 4 has pins 0..4 (0x1F), port 8 has pins 0..3 (0x0F), and port 10 has pins 0..6 (0x7F). All other ports have all eight pins.
- R6: `pad_pup[8k+i]` is 1 only when the stored pull-up bit is 1 and `pin_dir_out[8k+i]` is 0. An output pin never has a pull-up, whatever function drives it.
- R7: A write while `wp_en` is 1 leaves every register unchanged. Reads still return the stored values.
- R8: Reads from any address other than base..base+12 return 0x00. Writes to those addresses change nothing.
- R9: `bus_rdata` is combinational from `bus_addr` and changes in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 24 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| wp_en | input | 1 | Write protection active when 1 |
| pin_dir_out | input | 96 | Per-pin direction, 1 = output |
| mc_addr | input | 26 | Address from the memory controller |
| mc_data | input | 16 | Data from the memory controller |
| pad_pup | output | 96 | Effective per-pin pull-up enable |
| pad_addr | output | 26 | External address bus value |
| pad_data | output | 16 | External data bus value |

## Verification
The assertions check four things on every cycle:
- no output pin ever receives a pull-up, and no missing pin holds a pull-up bit;
- a protected write leaves all stored state unchanged;
- the reserved drive bits read zero;
- a committed force bit clears its bus on the following cycle.

Only the bench scenarios can show the rest:
- the exact reset values;
- the address decoding of every port and of the unmapped gap;
- the masking of written data;
- the pass-through of random memory-controller values once a force is released.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;
    typedef struct packed {
        logic dat_low;
        logic adr_low;
    } drv_ctl_t;

    localparam drv_ctl_t DRV_RST = '{dat_low: 1'b0, adr_low: 1'b0};
endpackage

// File: rtl/pad_reg_file.sv
module pad_reg_file
    import pad_ctl_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [23:0] BASE     = 24'h300320,
    parameter int          NPORT    = 12,
    parameter int          PINS     = 8,
    parameter logic [NPORT*PINS-1:0] PIN_MASK = '1,
    parameter logic [NPORT*PINS-1:0] PUP_RST  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_i,
    input  logic [PINS-1:0]       wdata_i,
    input  logic                  wp_i,
    output logic [PINS-1:0]       rdata_o,
    output drv_ctl_t              drv_o,
    output logic [NPORT*PINS-1:0] pup_o
);
    localparam int PUP_W = NPORT * PINS;
    localparam int OFF_W = $clog2(NPORT + 1);
    localparam int WIN   = 2 ** OFF_W;

    drv_ctl_t           drv_d, drv_q;
    logic [PUP_W-1:0]   pup_d, pup_q;
    logic [ADDR_W-1:0]  diff;
    logic               in_win;
    logic [OFF_W-1:0]   off;
    logic               wr_ok;

    always_comb begin
        diff   = addr_i - ADDR_W'(BASE);
        in_win = (addr_i >= ADDR_W'(BASE)) && (diff < ADDR_W'(WIN));
        off    = diff[OFF_W-1:0];
        wr_ok  = wr_i && !wp_i && in_win;
        drv_d  = drv_q;
        pup_d  = pup_q;
        if (wr_ok && off == '0) begin
            drv_d.dat_low = wdata_i[1];
            drv_d.adr_low = wdata_i[0];
        end
        for (int p = 0; p < NPORT; p++) begin
            if (wr_ok && off == OFF_W'(p + 1))
                pup_d[p*PINS +: PINS] = wdata_i & PIN_MASK[p*PINS +: PINS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= DRV_RST;
            pup_q <= PUP_RST & PIN_MASK;
        end else begin
            drv_q <= drv_d;
            pup_q <= pup_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (in_win) begin
            if (off == '0)
                rdata_o = {{(PINS-2){1'b0}}, drv_q.dat_low, drv_q.adr_low};
            for (int p = 0; p < NPORT; p++) begin
                if (off == OFF_W'(p + 1))
                    rdata_o = pup_q[p*PINS +: PINS];
            end
        end
    end

    assign drv_o = drv_q;
    assign pup_o = pup_q;

    // R7: protected write keeps all state
    a_r7_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wp_i) |=> ($stable(drv_q) && $stable(pup_q)));
    // R5: missing pins never hold a bit
    a_r5_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pup_q & ~PIN_MASK) == '0);
    // R2: reserved drive bits read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(BASE)) |-> (rdata_o[PINS-1:2] == '0));
endmodule

// File: rtl/pad_pup_gate.sv
module pad_pup_gate #(
    parameter int NPORT = 12,
    parameter int PINS  = 8
) (
    input  logic [NPORT*PINS-1:0] pup_i,
    input  logic [NPORT*PINS-1:0] dir_out_i,
    output logic [NPORT*PINS-1:0] pup_o
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign pup_o[p*PINS +: PINS] = pup_i[p*PINS +: PINS] & ~dir_out_i[p*PINS +: PINS];
    end
endmodule

// File: rtl/pad_bus_force.sv
module pad_bus_force #(
    parameter int W = 16
) (
    input  logic         force_i,
    input  logic [W-1:0] norm_i,
    output logic [W-1:0] pad_o
);
    assign pad_o = force_i ? '0 : norm_i;
endmodule

// File: rtl/pad_ctl_bank.sv
module pad_ctl_bank
    import pad_ctl_pkg::*;
#(
    parameter int          ADDR_W = 24,
    parameter logic [23:0] BASE   = 24'h300320,
    parameter int          NPORT  = 12,
    parameter int          PINS   = 8,
    parameter int          EXT_AW = 26,
    parameter int          EXT_DW = 16,
    parameter logic [NPORT*PINS-1:0] PIN_MASK = {
        8'hFF, 8'h7F, 8'hFF, 8'h0F, 8'hFF, 8'hFF,
        8'hFF, 8'h1F, 8'hFF, 8'h3F, 8'hFF, 8'hFF},
    parameter logic [NPORT*PINS-1:0] PUP_RST = {
        8'h00, 8'h02, 8'h00, 8'h00, 8'h80, 8'hFF,
        8'h08, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [PINS-1:0]       bus_wdata,
    output logic [PINS-1:0]       bus_rdata,
    input  logic                  wp_en,
    input  logic [NPORT*PINS-1:0] pin_dir_out,
    input  logic [EXT_AW-1:0]     mc_addr,
    input  logic [EXT_DW-1:0]     mc_data,
    output logic [NPORT*PINS-1:0] pad_pup,
    output logic [EXT_AW-1:0]     pad_addr,
    output logic [EXT_DW-1:0]     pad_data
);
    drv_ctl_t              drv;
    logic [NPORT*PINS-1:0] pup_raw;

    pad_reg_file #(
        .ADDR_W(ADDR_W), .BASE(BASE), .NPORT(NPORT), .PINS(PINS),
        .PIN_MASK(PIN_MASK), .PUP_RST(PUP_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .wp_i(wp_en), .rdata_o(bus_rdata),
        .drv_o(drv), .pup_o(pup_raw)
    );

    pad_pup_gate #(.NPORT(NPORT), .PINS(PINS)) u_gate (
        .pup_i(pup_raw), .dir_out_i(pin_dir_out), .pup_o(pad_pup)
    );

    pad_bus_force #(.W(EXT_AW)) u_force_a (
        .force_i(drv.adr_low), .norm_i(mc_addr), .pad_o(pad_addr)
    );
    pad_bus_force #(.W(EXT_DW)) u_force_d (
        .force_i(drv.dat_low), .norm_i(mc_data), .pad_o(pad_data)
    );

    // R6: output pins never pulled up
    a_r6_no_pup_on_output: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pup & pin_dir_out) == '0);
    // R3: committed data force clears the data bus next cycle
    a_r3_data_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wp_en && bus_addr == ADDR_W'(BASE) && bus_wdata[1]) |=> (pad_data == '0));
    // R4: committed address force clears the address bus next cycle
    a_r4_addr_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wp_en && bus_addr == ADDR_W'(BASE) && bus_wdata[0]) |=> (pad_addr == '0));
endmodule

// File: tb/sim_pad_ctl_bank.sv
`timescale 1ns/1ps
module sim_pad_ctl_bank;
    localparam logic [23:0] BASE = 24'h300320;
    localparam logic [95:0] MASK = {
        8'hFF, 8'h7F, 8'hFF, 8'h0F, 8'hFF, 8'hFF,
        8'hFF, 8'h1F, 8'hFF, 8'h3F, 8'hFF, 8'hFF};
    localparam logic [95:0] RSTV = {
        8'h00, 8'h02, 8'h00, 8'h00, 8'h80, 8'hFF,
        8'h08, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        wp_en = 1'b0;
    logic [95:0] pin_dir_out = '0;
    logic [25:0] mc_addr = '0;
    logic [15:0] mc_data = '0;
    logic [95:0] pad_pup;
    logic [25:0] pad_addr;
    logic [15:0] pad_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0]  drv_m;
    logic [95:0] pup_m;

    always #4 clk = ~clk;

    pad_ctl_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wp_en(wp_en),
        .pin_dir_out(pin_dir_out), .mc_addr(mc_addr), .mc_data(mc_data),
        .pad_pup(pad_pup), .pad_addr(pad_addr), .pad_data(pad_data)
    );

    function automatic logic [7:0] exp_read(input logic [23:0] a);
        if (a == BASE) return {6'b0, drv_m};
        for (int p = 0; p < 12; p++)
            if (a == BASE + 24'(p + 1)) return pup_m[p*8 +: 8];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [23:0] a, input logic [7:0] d, input logic wp);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; wp_en = wp;
        @(posedge clk);
        if (!wp) begin
            if (a == BASE) drv_m = d[1:0];
            for (int p = 0; p < 12; p++)
                if (a == BASE + 24'(p + 1)) pup_m[p*8 +: 8] = d & MASK[p*8 +: 8];
        end
        @(negedge clk);
        bus_wr = 1'b0; wp_en = 1'b0;
    endtask

    task automatic check_read(input string req, input logic [23:0] a);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, 128'(bus_rdata), 128'(exp_read(a)));
    endtask

    task automatic check_pads(input string req);
        @(negedge clk);
        pin_dir_out = {$urandom, $urandom, $urandom};
        mc_addr = 26'($urandom);
        mc_data = 16'($urandom);
        #1;
        check({req, " R6 pull-up"}, 128'(pad_pup), 128'(pup_m & ~pin_dir_out));
        check({req, " R3 data bus"}, 128'(pad_data), 128'(drv_m[1] ? 16'h0 : mc_data));
        check({req, " R4 addr bus"}, 128'(pad_addr), 128'(drv_m[0] ? 26'h0 : mc_addr));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        drv_m = 2'b00;
        pup_m = RSTV;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values of every register
        for (int p = 0; p <= 12; p++) check_read("R1 reset", BASE + 24'(p));
        // R2: drive register write and reserved bits
        do_write(BASE, 8'hFF, 1'b0);
        check_read("R2 drive readback", BASE);
        check_pads("R2 both forced");
        do_write(BASE, 8'h02, 1'b0);
        check_pads("R3 data only");
        do_write(BASE, 8'h01, 1'b0);
        check_pads("R4 addr only");
        do_write(BASE, 8'h00, 1'b0);
        check_pads("R3 R4 released");
        // R5: masked ports reject missing pins
        do_write(BASE + 24'd3, 8'hFF, 1'b0);
        check_read("R5 port2 mask", BASE + 24'd3);
        do_write(BASE + 24'd9, 8'hFF, 1'b0);
        check_read("R5 port8 mask", BASE + 24'd9);
        // R6: all outputs then all inputs
        @(negedge clk);
        pin_dir_out = '1;
        #1 check("R6 all outputs", 128'(pad_pup), 128'(0));
        pin_dir_out = '0;
        #1 check("R6 all inputs", 128'(pad_pup), 128'(pup_m));
        // R7: protected writes ignored
        do_write(BASE, 8'h03, 1'b1);
        check_read("R7 protected drive", BASE);
        do_write(BASE + 24'd1, 8'h5A, 1'b1);
        check_read("R7 protected pull-up", BASE + 24'd1);
        check_pads("R7 pads after protected");
        // R8: unmapped reads and writes
        do_write(BASE + 24'd13, 8'hFF, 1'b0);
        check_read("R8 gap read", BASE + 24'd13);
        check_read("R8 below base", BASE - 24'd1);
        check_read("R8 far address", 24'h000321);
        for (int p = 0; p <= 12; p++) check_read("R8 no side effect", BASE + 24'(p));
        // R9: combinational read follows address within the cycle
        @(negedge clk);
        bus_addr = BASE + 24'd7;
        #1 check("R9 comb read a", 128'(bus_rdata), 128'(exp_read(BASE + 24'd7)));
        bus_addr = BASE + 24'd8;
        #1 check("R9 comb read b", 128'(bus_rdata), 128'(exp_read(BASE + 24'd8)));
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [23:0] a;
            a = ($urandom % 10 == 0) ? 24'($urandom) : BASE + 24'($urandom % 16);
            if ($urandom % 2 == 0)
                do_write(a, 8'($urandom), ($urandom % 10) < 3);
            check_read("R5 R7 R8 random read", a);
            if (i % 8 == 0) check_pads("R3 R4 R6 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule